// File: doc/BRIEF.md
# Instruction Decoder with Register Scoreboard

This block is the decode stage of an in-order pipeline. A 32-bit instruction word arrives on a valid/ready stream. The block reads the format code from the two lowest bits, extracts the opcode and the register and immediate fields, and checks every register the instruction reads against a small queue of registers that older in-flight instructions have claimed. If a source is claimed, the word is held back. Otherwise the block claims the destination register or registers, samples two scalar register-file read ports and the vector-length register, and presents the decoded result on an output valid/ready stream. Writeback frees the oldest claim with a one-cycle release pulse.

Back-pressure rules: an input word is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` depends on the word currently offered, because the hazard check decodes it. The output register reloads only when it is empty or is being consumed in the same cycle. While `out_valid` is high and `out_ready` is low, every output field stays unchanged.

Top module: `idsb_decode`

## Requirements
- R1: `out_op` is `{opcode, format}`. Formats: 00 register (5-bit opcode, bits 6:2), 01 immediate (4-bit opcode, bits 5:2, zero-extended to 5), 10 jump (4-bit opcode, bits 5:2). Known opcodes are register ADD=0, SUB=1, XOR=2, CMP=3, VADD=4, VCMP=5; immediate ADDI=0, LOAD=1, STORE=2, VLOAD=3, VSTORE=4; jump JMP=0, BEQ=1, PUSH=2, POP=3. Format 11 and any other opcode give `out_op` = 7'h7F with all fields, operands and vector length zero.
- R2: Register format takes fields A=[11:7], B=[16:12] and C=[21:17], with immediate 0. Immediate and jump formats take A=[10:6]. The immediate format also takes B=[15:11] and immediate = sign-extended [31:16]. The jump format takes offset = sign-extended [31:11], with B=C=0.
- R3: `rf_ra_idx`/`rf_rb_idx` carry fields A/B of the offered word. `out_va`/`out_vb` hold the read-port values sampled when the word is accepted.
- R4: Sources checked against the claim queue: A and B for every register op, STORE and VSTORE. B only for ADDI, LOAD and VLOAD. A only for JMP, BEQ and PUSH. A checked source in the queue holds `in_ready` low.
- R5: On acceptance the destination is claimed. This is C for ADD, SUB, XOR and VADD, and A for ADDI, LOAD, VLOAD and POP. Register 0 is never claimed.
- R6: CMP, VCMP, STORE, VSTORE, JMP and BEQ claim nothing.
- R7: For VADD, VCMP, VLOAD and VSTORE, `out_vlen` = min(low 4 bits of register 4, VLMAX). The word stalls while register 4 is claimed. Other ops give 0.
- R8: PUSH and POP stall while register 2 is claimed and claim register 2 on acceptance, after the POP destination.
- R9: A `wb_release` pulse removes the oldest claim at the clock edge. It has no effect on an empty queue.
- R10: A word whose claims would exceed SB_DEPTH free entries stalls.
- R11: Output fields are held while `out_valid` and not `out_ready`, and no new word is taken then.
- R12: After reset `out_valid` is 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Word can be taken this cycle |
| in_instr | input | 32 | Raw instruction word |
| rf_ra_idx | output | 5 | Read-port address, field A |
| rf_rb_idx | output | 5 | Read-port address, field B |
| rf_ra_val | input | 32 | Register value at rf_ra_idx |
| rf_rb_val | input | 32 | Register value at rf_rb_idx |
| rf_vl_val | input | 32 | Value of the vector-length register (4) |
| wb_release | input | 1 | Free the oldest claim |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| out_op | output | 7 | {opcode, format} or 7'h7F |
| out_ra | output | 5 | Field A |
| out_rb | output | 5 | Field B |
| out_rc | output | 5 | Field C |
| out_va | output | 32 | Value read for A |
| out_vb | output | 32 | Value read for B |
| out_imm | output | 32 | Sign-extended immediate or offset |
| out_vlen | output | VL_W | Resolved vector length |

## Verification
On every cycle the assertions check that a held output stays unchanged, that the resolved length never passes VLMAX, that the claim count stays within the queue depth and drops by one on a lone release, that register 0 is never queued, and that stack-pointer claims come only from PUSH and POP. Which sources stall, what each op claims, the ordering of claims against releases, the field positions and sign extension, and the clamp values can only be shown by the bench's scenarios. The bench drives a long pseudo-random instruction mix against an arithmetic model of the claim queue.

// File: rtl/idsb_pkg.sv
package idsb_pkg;
  localparam int XLEN   = 32;
  localparam int TYPE_W = 2;
  localparam int OPC_RW = 5;
  localparam int OPC_W  = 4;
  localparam int REG_W  = 5;
  localparam int OP_W   = OPC_RW + TYPE_W;

  typedef enum logic [TYPE_W-1:0] {
    FMT_REG = 2'b00, FMT_IMM = 2'b01, FMT_JMP = 2'b10, FMT_NONE = 2'b11
  } fmt_e;

  localparam logic [OP_W-1:0] OP_NOP = '1;

  localparam logic [OPC_RW-1:0] R_ADD = 5'd0, R_SUB = 5'd1, R_XOR = 5'd2,
                                R_CMP = 5'd3, R_VADD = 5'd4, R_VCMP = 5'd5;
  localparam logic [OPC_W-1:0]  I_ADDI = 4'd0, I_LOAD = 4'd1, I_STORE = 4'd2,
                                I_VLOAD = 4'd3, I_VSTORE = 4'd4;
  localparam logic [OPC_W-1:0]  J_JMP = 4'd0, J_BEQ = 4'd1, J_PUSH = 4'd2,
                                J_POP = 4'd3;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
    logic [REG_W-1:0] rc;
    logic [XLEN-1:0]  imm;
    logic             chk_a;
    logic             chk_b;
    logic             need_vl;
    logic             use_sp;
    logic             dst_en;
    logic [REG_W-1:0] dst;
  } dec_t;
endpackage

// File: rtl/idsb_split.sv
module idsb_split
  import idsb_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            d
);
  localparam int RBASE = TYPE_W + OPC_RW;
  localparam int IBASE = TYPE_W + OPC_W;

  logic [OPC_RW-1:0] opr;
  logic [OPC_W-1:0]  opn;
  logic              known;

  assign opr = instr[TYPE_W +: OPC_RW];
  assign opn = instr[TYPE_W +: OPC_W];

  always_comb begin
    d     = '0;
    known = 1'b0;
    case (fmt_e'(instr[TYPE_W-1:0]))
      FMT_REG: begin
        d.ra    = instr[RBASE +: REG_W];
        d.rb    = instr[RBASE+REG_W +: REG_W];
        d.rc    = instr[RBASE+2*REG_W +: REG_W];
        d.op    = {opr, instr[TYPE_W-1:0]};
        d.chk_a = 1'b1;
        d.chk_b = 1'b1;
        known   = (opr <= R_VCMP);
        d.need_vl = (opr == R_VADD) || (opr == R_VCMP);
        d.dst     = d.rc;
        d.dst_en  = (opr != R_CMP) && (opr != R_VCMP);
      end
      FMT_IMM: begin
        d.ra  = instr[IBASE +: REG_W];
        d.rb  = instr[IBASE+REG_W +: REG_W];
        d.imm = XLEN'($signed(instr[XLEN-1:IBASE+2*REG_W]));
        d.op  = {OPC_RW'(opn), instr[TYPE_W-1:0]};
        known = 1'b1;
        case (opn)
          I_ADDI, I_LOAD: begin d.chk_b = 1'b1; d.dst = d.ra; d.dst_en = 1'b1; end
          I_STORE:        begin d.chk_a = 1'b1; d.chk_b = 1'b1; end
          I_VLOAD: begin
            d.chk_b = 1'b1; d.need_vl = 1'b1; d.dst = d.ra; d.dst_en = 1'b1;
          end
          I_VSTORE: begin d.chk_a = 1'b1; d.chk_b = 1'b1; d.need_vl = 1'b1; end
          default: known = 1'b0;
        endcase
      end
      FMT_JMP: begin
        d.ra  = instr[IBASE +: REG_W];
        d.imm = XLEN'($signed(instr[XLEN-1:IBASE+REG_W]));
        d.op  = {OPC_RW'(opn), instr[TYPE_W-1:0]};
        known = 1'b1;
        case (opn)
          J_JMP, J_BEQ: d.chk_a = 1'b1;
          J_PUSH:       begin d.chk_a = 1'b1; d.use_sp = 1'b1; end
          J_POP:        begin d.use_sp = 1'b1; d.dst = d.ra; d.dst_en = 1'b1; end
          default: known = 1'b0;
        endcase
      end
      default: known = 1'b0;
    endcase
    if (!known) begin
      d    = '0;
      d.op = OP_NOP;
    end
    d.dst_en = d.dst_en && (d.dst != '0);
  end
endmodule

// File: rtl/idsb_scoreboard.sv
module idsb_scoreboard #(
  parameter int DEPTH = 8,
  parameter int REG_W = 5,
  parameter int NQ    = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pop,
  input  logic                      push0,
  input  logic [REG_W-1:0]          d0,
  input  logic                      push1,
  input  logic [REG_W-1:0]          d1,
  input  logic [NQ-1:0][REG_W-1:0]  q_addr,
  output logic [NQ-1:0]             q_hit,
  output logic [CW-1:0]             count
);
  logic [DEPTH-1:0][REG_W-1:0] ent, ent_n;
  logic [CW-1:0]               cnt, cnt_n;

  assign count = cnt;

  for (genvar k = 0; k < NQ; k++) begin : g_q
    logic [DEPTH-1:0] m;
    for (genvar e = 0; e < DEPTH; e++) begin : g_e
      assign m[e] = (CW'(e) < cnt) && (ent[e] == q_addr[k]);
    end
    assign q_hit[k] = |m;
  end

  always_comb begin
    ent_n = ent;
    cnt_n = cnt;
    if (pop && cnt != '0) begin
      for (int i = 0; i < DEPTH-1; i++) ent_n[i] = ent[i+1];
      ent_n[DEPTH-1] = '0;
      cnt_n = cnt - CW'(1);
    end
    if (push0 && cnt_n < CW'(DEPTH)) begin
      ent_n[cnt_n[IW-1:0]] = d0;
      cnt_n = cnt_n + CW'(1);
    end
    if (push1 && cnt_n < CW'(DEPTH)) begin
      ent_n[cnt_n[IW-1:0]] = d1;
      cnt_n = cnt_n + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent <= '0;
      cnt <= '0;
    end else begin
      ent <= ent_n;
      cnt <= cnt_n;
    end
  end

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt != '0 && !push0 && !push1) |=> cnt == $past(cnt) - CW'(1));
  p_no_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push0 |-> d0 != '0);
endmodule

// File: rtl/idsb_decode.sv
module idsb_decode
  import idsb_pkg::*;
#(
  parameter int VLMAX     = 8,
  parameter int SB_DEPTH  = 8,
  parameter int VL_MASK_W = 4,
  parameter int VL_REG    = 4,
  parameter int SP_REG    = 2,
  localparam int VL_W     = $clog2(VLMAX + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_instr,
  output logic [4:0]       rf_ra_idx,
  output logic [4:0]       rf_rb_idx,
  input  logic [31:0]      rf_ra_val,
  input  logic [31:0]      rf_rb_val,
  input  logic [31:0]      rf_vl_val,
  input  logic             wb_release,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [6:0]       out_op,
  output logic [4:0]       out_ra,
  output logic [4:0]       out_rb,
  output logic [4:0]       out_rc,
  output logic [31:0]      out_va,
  output logic [31:0]      out_vb,
  output logic [31:0]      out_imm,
  output logic [VL_W-1:0]  out_vlen
);
  localparam int CW = $clog2(SB_DEPTH + 1);

  dec_t                    dec;
  logic [3:0]              hit;
  logic [3:0][REG_W-1:0]   qaddr;
  logic [CW-1:0]           sb_cnt;
  logic                    src_stall, room_ok, fire;
  logic [VL_MASK_W-1:0]    vl_raw;
  logic [VL_W-1:0]         vlen;

  idsb_split u_split (.instr(in_instr), .d(dec));

  assign qaddr = {REG_W'(SP_REG), REG_W'(VL_REG), dec.rb, dec.ra};

  idsb_scoreboard #(.DEPTH(SB_DEPTH), .REG_W(REG_W), .NQ(4)) u_sb (
    .clk(clk), .rst_n(rst_n), .pop(wb_release),
    .push0(fire && dec.dst_en), .d0(dec.dst),
    .push1(fire && dec.use_sp), .d1(REG_W'(SP_REG)),
    .q_addr(qaddr), .q_hit(hit), .count(sb_cnt));

  assign src_stall = (dec.chk_a && hit[0]) || (dec.chk_b && hit[1]) ||
                     (dec.need_vl && hit[2]) || (dec.use_sp && hit[3]);
  assign room_ok   = (int'(sb_cnt) + int'(dec.dst_en) + int'(dec.use_sp)) <= SB_DEPTH;
  assign in_ready  = !src_stall && room_ok && (!out_valid || out_ready);
  assign fire      = in_valid && in_ready;

  assign rf_ra_idx = dec.ra;
  assign rf_rb_idx = dec.rb;

  assign vl_raw = rf_vl_val[VL_MASK_W-1:0];
  assign vlen   = (int'(vl_raw) > VLMAX) ? VL_W'(VLMAX) : VL_W'(vl_raw);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_op    <= '0;
      out_ra    <= '0;
      out_rb    <= '0;
      out_rc    <= '0;
      out_va    <= '0;
      out_vb    <= '0;
      out_imm   <= '0;
      out_vlen  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_op    <= dec.op;
      out_ra    <= dec.ra;
      out_rb    <= dec.rb;
      out_rc    <= dec.rc;
      out_va    <= rf_ra_val;
      out_vb    <= rf_rb_val;
      out_imm   <= dec.imm;
      out_vlen  <= dec.need_vl ? vlen : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_imm)
                                   && $stable(out_va) && $stable(out_vlen)));
  p_vlen_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_vlen) <= VLMAX);
  p_sp_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec.use_sp) |=> (out_op == {OPC_RW'(J_PUSH), FMT_JMP} ||
                              out_op == {OPC_RW'(J_POP), FMT_JMP}));
endmodule

// File: tb/sim_idsb_decode.sv
`timescale 1ns/1ps
module sim_idsb_decode;
  localparam int VLMAX = 8;
  localparam int DEPTH = 8;
  localparam logic [31:0] NOPW = 32'h0000_0003;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, wb_release = 1'b0, out_valid, out_ready = 1'b1;
  logic [31:0] in_instr = NOPW, rf_ra_val, rf_rb_val, rf_vl_val = '0;
  logic [4:0]  rf_ra_idx, rf_rb_idx, out_ra, out_rb, out_rc;
  logic [6:0]  out_op;
  logic [31:0] out_va, out_vb, out_imm;
  logic [3:0]  out_vlen;

  always #2 clk = ~clk;

  assign rf_ra_val = 32'(rf_ra_idx) * 32'h0001_0003 + 32'h100;
  assign rf_rb_val = 32'(rf_rb_idx) * 32'h0007_0001 + 32'h2000;

  idsb_decode #(.VLMAX(VLMAX), .SB_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .rf_ra_idx(rf_ra_idx), .rf_rb_idx(rf_rb_idx),
    .rf_ra_val(rf_ra_val), .rf_rb_val(rf_rb_val), .rf_vl_val(rf_vl_val),
    .wb_release(wb_release), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_ra(out_ra), .out_rb(out_rb), .out_rc(out_rc),
    .out_va(out_va), .out_vb(out_vb), .out_imm(out_imm), .out_vlen(out_vlen));

  int n_chk = 0, n_fail = 0;
  logic [4:0] mq [DEPTH];
  int mcnt = 0;
  bit mov = 0;
  logic [6:0] e_op, eo_op;
  logic [4:0] e_ra, e_rb, e_rc, e_dst, eo_ra, eo_rb, eo_rc;
  logic [31:0] e_imm, eo_imm, eo_va, eo_vb;
  logic [3:0] eo_vl;
  bit e_ca, e_cb, e_vl, e_sp;
  int unsigned seed = 32'h1234_5677;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkR(input int op, input int a, input int b, input int c);
    return {10'h2A5, 5'(c), 5'(b), 5'(a), 5'(op), 2'b00};
  endfunction
  function automatic logic [31:0] mkI(input int op, input int a, input int b, input logic [15:0] imm);
    return {imm, 5'(b), 5'(a), 4'(op), 2'b01};
  endfunction
  function automatic logic [31:0] mkJ(input int op, input int a, input logic [20:0] off);
    return {off, 5'(a), 4'(op), 2'b10};
  endfunction

  function automatic bit mhit(input logic [4:0] r);
    for (int i = 0; i < mcnt; i++) if (mq[i] == r) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int unsigned nxt();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic exp_decode(input logic [31:0] w);
    int op;
    e_op = 7'h7F; e_ra = 0; e_rb = 0; e_rc = 0; e_imm = 0; e_dst = 0;
    e_ca = 0; e_cb = 0; e_vl = 0; e_sp = 0;
    case (w[1:0])
      2'b00: begin
        op = int'(w[6:2]);
        if (op <= 5) begin
          e_op = {w[6:2], 2'b00}; e_ra = w[11:7]; e_rb = w[16:12]; e_rc = w[21:17];
          e_ca = 1; e_cb = 1; e_vl = (op == 4 || op == 5);
          if (op != 3 && op != 5) e_dst = e_rc;
        end
      end
      2'b01: begin
        op = int'(w[5:2]);
        if (op <= 4) begin
          e_op = {1'b0, w[5:2], 2'b01}; e_ra = w[10:6]; e_rb = w[15:11];
          e_imm = {{16{w[31]}}, w[31:16]};
          case (op)
            0, 1: begin e_cb = 1; e_dst = e_ra; end
            2:    begin e_ca = 1; e_cb = 1; end
            3:    begin e_cb = 1; e_vl = 1; e_dst = e_ra; end
            default: begin e_ca = 1; e_cb = 1; e_vl = 1; end
          endcase
        end
      end
      2'b10: begin
        op = int'(w[5:2]);
        if (op <= 3) begin
          e_op = {1'b0, w[5:2], 2'b10}; e_ra = w[10:6];
          e_imm = {{11{w[31]}}, w[31:11]};
          case (op)
            0, 1: e_ca = 1;
            2:    begin e_ca = 1; e_sp = 1; end
            default: begin e_sp = 1; e_dst = e_ra; end
          endcase
        end
      end
      default: ;
    endcase
  endtask

  task automatic step(input logic [31:0] w, input bit rel, input bit ordy, input string tag);
    bit src, vlh, sph, room, er, acc;
    string t;
    in_instr = w; in_valid = 1'b1; wb_release = rel; out_ready = ordy;
    #1;
    exp_decode(w);
    src  = (e_ca && mhit(e_ra)) || (e_cb && mhit(e_rb));
    vlh  = e_vl && mhit(5'd4);
    sph  = e_sp && mhit(5'd2);
    room = (mcnt + int'(e_dst != 0) + int'(e_sp)) <= DEPTH;
    er   = !src && !vlh && !sph && room && (!mov || ordy);
    t = tag;
    if (t == "") t = !room ? "R10" : sph ? "R8" : vlh ? "R7" : src ? "R4" : "R11";
    chk(in_ready == er, t, 32'(in_ready), 32'(er));
    chk(rf_ra_idx == e_ra && rf_rb_idx == e_rb, "R3", {rf_ra_idx, rf_rb_idx}, {e_ra, e_rb});
    acc = er;
    @(posedge clk);
    if (rel && mcnt > 0) begin
      for (int i = 0; i < DEPTH-1; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (acc) begin
      if (e_dst != 0) begin mq[mcnt] = e_dst; mcnt++; end
      if (e_sp) begin mq[mcnt] = 5'd2; mcnt++; end
      eo_op = e_op; eo_ra = e_ra; eo_rb = e_rb; eo_rc = e_rc; eo_imm = e_imm;
      eo_va = 32'(e_ra) * 32'h0001_0003 + 32'h100;
      eo_vb = 32'(e_rb) * 32'h0007_0001 + 32'h2000;
      eo_vl = !e_vl ? 4'd0 : (rf_vl_val[3:0] > 4'(VLMAX)) ? 4'(VLMAX) : rf_vl_val[3:0];
      mov = 1;
    end else if (ordy) mov = 0;
    @(negedge clk);
    chk(out_valid == mov, "R11", 32'(out_valid), 32'(mov));
    if (mov) begin
      chk(out_op == eo_op, "R1", 32'(out_op), 32'(eo_op));
      chk({out_ra, out_rb, out_rc} == {eo_ra, eo_rb, eo_rc}, "R2",
          32'({out_ra, out_rb, out_rc}), 32'({eo_ra, eo_rb, eo_rc}));
      chk(out_imm == eo_imm, "R2", out_imm, eo_imm);
      chk(out_va == eo_va && out_vb == eo_vb, "R3", out_va ^ out_vb, eo_va ^ eo_vb);
      chk(out_vlen == eo_vl, "R7", 32'(out_vlen), 32'(eo_vl));
    end
  endtask

  task automatic drain();
    while (mcnt > 0) step(NOPW, 1'b1, 1'b1, "R9");
    step(NOPW, 1'b0, 1'b1, "R9");
  endtask

  function automatic logic [4:0] pick(input logic [3:0] r);
    return r[3] ? 5'(16 + int'(r[1:0])) : {2'b00, r[2:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R12", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R12", 32'(in_ready), 1);
    @(negedge clk);
    // claim and release ordering
    step(mkR(0, 1, 2, 3), 0, 1, "R1");
    step(mkR(1, 3, 0, 4), 0, 1, "R5");
    step(mkR(1, 3, 0, 4), 1, 1, "R5");
    step(mkR(1, 3, 0, 4), 0, 1, "R9");
    // ops that claim nothing
    step(mkR(3, 5, 5, 9), 0, 1, "R6");
    step(mkI(2, 10, 11, 16'h8000), 0, 1, "R6");
    chk(out_imm == 32'hFFFF_8000, "R2", out_imm, 32'hFFFF_8000);
    step(mkR(0, 9, 10, 0), 0, 1, "R6");
    drain();
    // vector length
    rf_vl_val = 32'h2F;
    step(mkR(4, 16, 17, 18), 0, 1, "R7");
    chk(out_vlen == 4'd8, "R7", 32'(out_vlen), 8);
    rf_vl_val = 32'h25;
    step(mkR(5, 16, 17, 0), 0, 1, "R7");
    chk(out_vlen == 4'd5, "R7", 32'(out_vlen), 5);
    step(mkR(0, 0, 0, 4), 0, 1, "R5");
    step(mkI(4, 1, 16, 16'h0010), 0, 1, "R7");
    drain();
    // stack pointer
    step(mkJ(2, 5, 21'h1FFFFF), 0, 1, "R8");
    chk(out_imm == 32'hFFFF_FFFF, "R2", out_imm, 32'hFFFF_FFFF);
    step(mkJ(3, 6, 21'h0), 0, 1, "R8");
    drain();
    step(mkJ(3, 6, 21'h0), 0, 1, "R8");
    step(mkR(0, 6, 0, 7), 0, 1, "R8");
    drain();
    // queue capacity
    for (int i = 1; i <= DEPTH; i++) step(mkR(0, 0, 0, i), 0, 1, "R10");
    step(mkR(0, 0, 0, 9), 0, 1, "R10");
    drain();
    for (int i = 1; i < DEPTH; i++) step(mkR(0, 0, 0, i), 0, 1, "R10");
    step(mkJ(3, 12, 21'h0), 0, 1, "R10");
    drain();
    // no-op decodes
    step(32'hFFFF_FFFF, 0, 1, "R1");
    step(mkR(7, 1, 2, 3), 0, 1, "R1");
    step(mkI(6, 1, 2, 16'h1234), 0, 1, "R1");
    step(mkJ(9, 1, 21'h5), 0, 1, "R1");
    // back-pressure
    step(mkR(0, 1, 1, 5), 0, 0, "R11");
    step(mkR(0, 0, 0, 6), 0, 0, "R11");
    step(mkR(0, 0, 0, 6), 0, 1, "R11");
    drain();
    // pseudo-random sweep
    for (int n = 0; n < 4000; n++) begin
      int unsigned r1, r2, r3;
      logic [31:0] w;
      r1 = nxt(); r2 = nxt(); r3 = nxt();
      case (r1[1:0])
        2'b00: w = mkR(int'(r2[2:0]), int'(pick(r2[6:3])), int'(pick(r2[10:7])), int'(pick(r2[14:11])));
        2'b01: w = mkI(int'(r2[2:0]), int'(pick(r2[6:3])), int'(pick(r2[10:7])), r3[15:0]);
        2'b10: w = mkJ(int'(r2[2:0]), int'(pick(r2[6:3])), r3[20:0]);
        default: w = r1;
      endcase
      rf_vl_val = nxt();
      step(w, r3[31] | r3[30], r3[29:27] != 3'b000, "");
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule